// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration register file behind a host interface of two 8-bit ports. One port takes an index and the other carries data. After reset the file is closed to the host. It opens only when the host writes a two-byte key, 0x51 and then 0x23, on consecutive index-port writes. While the file is open, an index-port write selects a register, and later data-port writes and reads reach that register. A device-select register chooses which per-device bank the device-specific registers map to. Each bank holds an activate bit, a 16-bit base I/O address, two interrupt numbers, a DMA channel and a set of mode bytes. Every bank drives its settings out on parallel outputs, so the peripheral logic can use them directly. Writing 0xBB to the index port closes the file again.

The key handling is a three-state machine:

- `ST_LOCKED` is the closed state.
  - An index write of 0x51 moves it to `ST_KEY_HALF`.
- `ST_KEY_HALF` is the state after half the key.
  - An index write of 0x23 moves it to `ST_OPEN`.
  - An index write of 0x51 stays in `ST_KEY_HALF`.
  - Any other index write returns to `ST_LOCKED`.
  - Any data write returns to `ST_LOCKED`.
- `ST_OPEN` is the open state.
  - An index write of 0xBB returns to `ST_LOCKED`.
  - Every other index write loads the index register.

Top module: `cfgport_top`

## Requirements
- R1: After reset, the block is `ST_LOCKED` and reads of both ports return 0xFF. Every bank outputs activate 0, base 0x0000, both IRQ numbers 0x00 and DMA channel 0x04. The device select and the index are 0.
- R2: Index-port writes (`port_sel`=0) of 0x51 and then 0x23, with no other write between them, open the block.
- R3: After 0x51, an index write of 0x51 restarts the key in the half-key state. An index write of any value other than 0x23 or 0x51 returns the block to locked. A data-port write also returns it to locked.
- R4: While the block is open, an index write of 0xBB locks it and leaves the index register unchanged.
- R5: While the block is not open, data-port writes change no register. Index writes change no register either, other than the key progress. Reads of both ports return 0xFF.
- R6: While the block is open, a read of the index port returns the index register.
- R7: Data register 0x07 is the device select. Writes of 0 to NDEV-1 are taken and larger values are ignored. It reads back its value.
- R8: Register 0x30 bit 0 of the selected bank drives `dev_en_o[d]`. It reads back as {7'b0, bit}.
- R9: Registers 0x60 and 0x61 of the selected bank set the high and low bytes of `dev_base_o[16*d +: 16]`.
- R10: Registers 0x70, 0x72 and 0x74 of the selected bank drive `dev_irq_o`, `dev_irq2_o` and `dev_dma_o`, each at bits `[8*d +: 8]`.
- R11: Registers 0xF0 to 0xF4 are mode bytes. Each bank stores and reads back its own copy.
- R12: A data write to register 0x02 with bit 0 set returns every bank, the device select and the index to their reset values, and the block stays open. With bit 0 clear, the write has no effect. Register 0x02 reads 0x00.
- R13: Writes to any other index are ignored, and reads of any other index return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read value of the port chosen by port_sel |
| dev_en_o | output | NDEV | Activate bit per device |
| dev_base_o | output | 16*NDEV | Base I/O address per device |
| dev_irq_o | output | 8*NDEV | First IRQ number per device |
| dev_irq2_o | output | 8*NDEV | Second IRQ number per device |
| dev_dma_o | output | 8*NDEV | DMA channel per device |

## Verification
Directed key sequences are run first:
- the clean key;
- 0x51 then a foreign byte;
- 0x51 repeated;
- a data write inside the key;
- the relock byte.

Together they separate the three state-machine transitions out of the half-key state. Bank writes go to two different devices, which shows whether the mode bytes and settings stay per bank or leak between banks. Device-select values at the edge of the range and beyond it test the range check. The soft-reset register is written with bit 0 clear and then set. A long seeded random mix of both ports, drawn from the key bytes, register indices and random data, then runs against a bench model of the register file, and every port and output is compared after each write.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } lock_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h51;
    localparam logic [7:0] KEY_SECOND = 8'h23;
    localparam logic [7:0] KEY_CLOSE  = 8'hBB;

    localparam logic [7:0] REG_SOFTRST    = 8'h02;
    localparam logic [7:0] REG_DEVSEL     = 8'h07;
    localparam logic [7:0] REG_ACTIVE     = 8'h30;
    localparam logic [7:0] REG_BASE_HI    = 8'h60;
    localparam logic [7:0] REG_BASE_LO    = 8'h61;
    localparam logic [7:0] REG_IRQ_A      = 8'h70;
    localparam logic [7:0] REG_IRQ_B      = 8'h72;
    localparam logic [7:0] REG_DMA        = 8'h74;
    localparam logic [7:0] REG_MODE_FIRST = 8'hF0;

endpackage

// File: rtl/cfgport_lock_fsm.sv
module cfgport_lock_fsm
    import cfgport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        port_sel,
    input  logic [7:0]  wdata,
    output lock_state_e state_o,
    output logic        unlocked_o,
    output logic        idx_we_o,
    output logic        data_we_o
);

    lock_state_e state_q, state_d;
    logic        idx_wr, dat_wr;

    assign idx_wr = wr_en && !port_sel;
    assign dat_wr = wr_en &&  port_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_FIRST) state_d = ST_KEY_HALF;
            end
            ST_KEY_HALF: begin
                if (idx_wr) begin
                    if (wdata == KEY_SECOND)     state_d = ST_OPEN;
                    else if (wdata == KEY_FIRST) state_d = ST_KEY_HALF;
                    else                         state_d = ST_LOCKED;
                end else if (dat_wr) begin
                    state_d = ST_LOCKED;
                end
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_CLOSE) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        unlocked_o = (state_q == ST_OPEN);
        idx_we_o   = unlocked_o && idx_wr && (wdata != KEY_CLOSE);
        data_we_o  = unlocked_o && dat_wr;
    end

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter int         NMODE   = 5,
    parameter logic [7:0] DMA_RST = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        we_i,
    input  logic [7:0]  idx_i,
    input  logic [7:0]  wdata_i,
    output logic        en_o,
    output logic [15:0] base_o,
    output logic [7:0]  irq_o,
    output logic [7:0]  irq2_o,
    output logic [7:0]  dma_o,
    output logic [7:0]  rd_o
);

    logic       en_q;
    logic [7:0] base_hi_q, base_lo_q, irq_q, irq2_q, dma_q;
    logic [7:0] mode_q [NMODE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            base_hi_q <= 8'h00;
            base_lo_q <= 8'h00;
            irq_q     <= 8'h00;
            irq2_q    <= 8'h00;
            dma_q     <= DMA_RST;
            for (int m = 0; m < NMODE; m++) mode_q[m] <= 8'h00;
        end else if (clr_i) begin
            en_q      <= 1'b0;
            base_hi_q <= 8'h00;
            base_lo_q <= 8'h00;
            irq_q     <= 8'h00;
            irq2_q    <= 8'h00;
            dma_q     <= DMA_RST;
            for (int m = 0; m < NMODE; m++) mode_q[m] <= 8'h00;
        end else if (we_i) begin
            case (idx_i)
                REG_ACTIVE:  en_q      <= wdata_i[0];
                REG_BASE_HI: base_hi_q <= wdata_i;
                REG_BASE_LO: base_lo_q <= wdata_i;
                REG_IRQ_A:   irq_q     <= wdata_i;
                REG_IRQ_B:   irq2_q    <= wdata_i;
                REG_DMA:     dma_q     <= wdata_i;
                default: ;
            endcase
            for (int m = 0; m < NMODE; m++)
                if (idx_i == REG_MODE_FIRST + 8'(m)) mode_q[m] <= wdata_i;
        end
    end

    always_comb begin
        rd_o = 8'h00;
        case (idx_i)
            REG_ACTIVE:  rd_o = {7'b0, en_q};
            REG_BASE_HI: rd_o = base_hi_q;
            REG_BASE_LO: rd_o = base_lo_q;
            REG_IRQ_A:   rd_o = irq_q;
            REG_IRQ_B:   rd_o = irq2_q;
            REG_DMA:     rd_o = dma_q;
            default: ;
        endcase
        for (int m = 0; m < NMODE; m++)
            if (idx_i == REG_MODE_FIRST + 8'(m)) rd_o = mode_q[m];
    end

    assign en_o   = en_q;
    assign base_o = {base_hi_q, base_lo_q};
    assign irq_o  = irq_q;
    assign irq2_o = irq2_q;
    assign dma_o  = dma_q;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int         NDEV    = 9,
    parameter int         NMODE   = 5,
    parameter logic [7:0] DMA_RST = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 port_sel,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [NDEV-1:0]      dev_en_o,
    output logic [16*NDEV-1:0]   dev_base_o,
    output logic [8*NDEV-1:0]    dev_irq_o,
    output logic [8*NDEV-1:0]    dev_irq2_o,
    output logic [8*NDEV-1:0]    dev_dma_o
);

    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;

    lock_state_e     lock_state;
    logic            unlocked, idx_we, data_we, soft_clr;
    logic [7:0]      index_q;
    logic [SELW-1:0] devsel_q;
    logic [NDEV-1:0] bank_we;
    logic [7:0]      bank_rd [NDEV];
    logic [7:0]      sel_rd, data_val;

    cfgport_lock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .port_sel   (port_sel),
        .wdata      (wdata),
        .state_o    (lock_state),
        .unlocked_o (unlocked),
        .idx_we_o   (idx_we),
        .data_we_o  (data_we)
    );

    assign soft_clr = data_we && (index_q == REG_SOFTRST) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q  <= 8'h00;
            devsel_q <= '0;
        end else if (soft_clr) begin
            index_q  <= 8'h00;
            devsel_q <= '0;
        end else begin
            if (idx_we) index_q <= wdata;
            if (data_we && index_q == REG_DEVSEL && 32'(wdata) < NDEV)
                devsel_q <= wdata[SELW-1:0];
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_bank
        assign bank_we[d] = data_we && (devsel_q == SELW'(d));
        cfgport_bank #(.NMODE(NMODE), .DMA_RST(DMA_RST)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (soft_clr),
            .we_i    (bank_we[d]),
            .idx_i   (index_q),
            .wdata_i (wdata),
            .en_o    (dev_en_o[d]),
            .base_o  (dev_base_o[16*d +: 16]),
            .irq_o   (dev_irq_o[8*d +: 8]),
            .irq2_o  (dev_irq2_o[8*d +: 8]),
            .dma_o   (dev_dma_o[8*d +: 8]),
            .rd_o    (bank_rd[d])
        );
    end

    always_comb begin
        sel_rd = 8'h00;
        for (int d = 0; d < NDEV; d++)
            if (devsel_q == SELW'(d)) sel_rd = bank_rd[d];
    end

    always_comb begin
        case (index_q)
            REG_SOFTRST: data_val = 8'h00;
            REG_DEVSEL:  data_val = 8'(devsel_q);
            default:     data_val = sel_rd;
        endcase
    end

    assign rdata = !unlocked ? 8'hFF : (port_sel ? data_val : index_q);

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker
    import cfgport_pkg::*;
#(
    parameter int NDEV = 9,
    parameter int SELW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                port_sel,
    input logic [7:0]          wdata,
    input logic [7:0]          rdata,
    input lock_state_e         lock_state,
    input logic [7:0]          index_q,
    input logic [SELW-1:0]     devsel_q,
    input logic [NDEV-1:0]     dev_en_o,
    input logic [16*NDEV-1:0]  dev_base_o,
    input logic [NDEV-1:0]     bank_we
);

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == ST_KEY_HALF && wr_en && !port_sel && wdata == 8'h23
        |=> lock_state == ST_OPEN);

    assert_key_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == ST_KEY_HALF && wr_en && !port_sel && wdata != 8'h23 && wdata != 8'h51
        |=> lock_state == ST_LOCKED);

    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == ST_OPEN && wr_en && !port_sel && wdata == 8'hBB
        |=> lock_state == ST_LOCKED && $stable(index_q));

    assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != ST_OPEN |-> rdata == 8'hFF);

    assert_locked_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != ST_OPEN && wr_en && port_sel
        |=> $stable(dev_en_o) && $stable(dev_base_o) && $stable(devsel_q));

    assert_devsel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(devsel_q) < NDEV);

    assert_bank_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == ST_OPEN && wr_en && port_sel && index_q == 8'h02 && wdata[0]
        |=> dev_en_o == '0 && dev_base_o == '0 && devsel_q == '0 && lock_state == ST_OPEN);

endmodule

bind cfgport_top cfgport_checker #(.NDEV(NDEV), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .port_sel   (port_sel),
    .wdata      (wdata),
    .rdata      (rdata),
    .lock_state (lock_state),
    .index_q    (index_q),
    .devsel_q   (devsel_q),
    .dev_en_o   (dev_en_o),
    .dev_base_o (dev_base_o),
    .bank_we    (bank_we)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;

    localparam int ND = 9;
    localparam int NM = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [ND-1:0]    dev_en_o;
    logic [16*ND-1:0] dev_base_o;
    logic [8*ND-1:0]  dev_irq_o, dev_irq2_o, dev_dma_o;

    always #5 clk = ~clk;

    cfgport_top #(.NDEV(ND), .NMODE(NM)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata), .dev_en_o(dev_en_o), .dev_base_o(dev_base_o),
        .dev_irq_o(dev_irq_o), .dev_irq2_o(dev_irq2_o), .dev_dma_o(dev_dma_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model: 0 locked, 1 half key, 2 open
    int         m_st;
    logic [7:0] m_idx;
    int         m_sel;
    logic       m_en   [ND];
    logic [15:0] m_base [ND];
    logic [7:0] m_irq [ND], m_irq2 [ND], m_dma [ND];
    logic [7:0] m_mode [ND][NM];

    function automatic void mdl_reset();
        m_idx = 8'h00;
        m_sel = 0;
        for (int d = 0; d < ND; d++) begin
            m_en[d] = 1'b0; m_base[d] = 16'h0; m_irq[d] = 8'h0;
            m_irq2[d] = 8'h0; m_dma[d] = 8'h04;
            for (int m = 0; m < NM; m++) m_mode[d][m] = 8'h00;
        end
    endfunction

    function automatic void mdl_write(input logic p, input logic [7:0] v);
        if (!p) begin
            if (m_st == 2) begin
                if (v == 8'hBB) m_st = 0; else m_idx = v;
            end else if (m_st == 1) begin
                m_st = (v == 8'h23) ? 2 : (v == 8'h51) ? 1 : 0;
            end else if (v == 8'h51) begin
                m_st = 1;
            end
        end else if (m_st == 1) begin
            m_st = 0;
        end else if (m_st == 2) begin
            if (m_idx == 8'h02) begin
                if (v[0]) mdl_reset();
            end else if (m_idx == 8'h07) begin
                if (int'(v) < ND) m_sel = int'(v);
            end else if (m_idx == 8'h30) m_en[m_sel] = v[0];
            else if (m_idx == 8'h60) m_base[m_sel][15:8] = v;
            else if (m_idx == 8'h61) m_base[m_sel][7:0] = v;
            else if (m_idx == 8'h70) m_irq[m_sel] = v;
            else if (m_idx == 8'h72) m_irq2[m_sel] = v;
            else if (m_idx == 8'h74) m_dma[m_sel] = v;
            else if (m_idx >= 8'hF0 && m_idx < 8'hF0 + 8'(NM)) m_mode[m_sel][m_idx - 8'hF0] = v;
        end
    endfunction

    function automatic logic [7:0] exp_read(input logic p);
        if (m_st != 2) return 8'hFF;
        if (!p) return m_idx;
        if (m_idx == 8'h07) return 8'(m_sel);
        if (m_idx == 8'h30) return {7'b0, m_en[m_sel]};
        if (m_idx == 8'h60) return m_base[m_sel][15:8];
        if (m_idx == 8'h61) return m_base[m_sel][7:0];
        if (m_idx == 8'h70) return m_irq[m_sel];
        if (m_idx == 8'h72) return m_irq2[m_sel];
        if (m_idx == 8'h74) return m_dma[m_sel];
        if (m_idx >= 8'hF0 && m_idx < 8'hF0 + 8'(NM)) return m_mode[m_sel][m_idx - 8'hF0];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [7:0] v);
        @(negedge clk);
        port_sel = p; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_write(p, v);
    endtask

    task automatic rd(input logic p, output logic [7:0] v);
        port_sel = p;
        #1;
        v = rdata;
    endtask

    task automatic chk_rd(input string tag, input logic p, input logic [7:0] exp);
        logic [7:0] v;
        rd(p, v);
        chk(tag, 32'(v), 32'(exp));
    endtask

    task automatic compare_all(input string tag);
        chk_rd({tag, " R5 R6 index port"}, 1'b0, exp_read(1'b0));
        chk_rd({tag, " R5 R13 data port"}, 1'b1, exp_read(1'b1));
        for (int d = 0; d < ND; d++) begin
            chk({tag, " R8 enable"}, 32'(dev_en_o[d]), 32'(m_en[d]));
            chk({tag, " R9 base"}, 32'(dev_base_o[16*d +: 16]), 32'(m_base[d]));
            chk({tag, " R10 irq"}, 32'(dev_irq_o[8*d +: 8]), 32'(m_irq[d]));
            chk({tag, " R10 irq2"}, 32'(dev_irq2_o[8*d +: 8]), 32'(m_irq2[d]));
            chk({tag, " R10 dma"}, 32'(dev_dma_o[8*d +: 8]), 32'(m_dma[d]));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] pick [16];
        m_st = 0;
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd("R1 index read after reset", 1'b0, 8'hFF);
        chk_rd("R1 data read after reset", 1'b1, 8'hFF);
        chk("R1 dma default dev0", 32'(dev_dma_o[7:0]), 32'h04);
        compare_all("R1 reset");

        // R5 locked writes ignored
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h01);
        chk_rd("R5 locked data read", 1'b1, 8'hFF);
        chk("R5 locked enable", 32'(dev_en_o), 32'h0);

        // R3 wrong second byte
        wr(1'b0, 8'h51); wr(1'b0, 8'h00); wr(1'b0, 8'h23);
        chk_rd("R3 foreign byte aborts key", 1'b0, 8'hFF);
        // R3 repeated first byte
        wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
        chk_rd("R3 R6 repeated first key opens, index 0", 1'b0, 8'h00);
        // R4 relock
        wr(1'b0, 8'h70);
        wr(1'b0, 8'hBB);
        chk_rd("R4 relocked", 1'b0, 8'hFF);
        // R3 data write inside key
        wr(1'b0, 8'h51); wr(1'b1, 8'h00); wr(1'b0, 8'h23);
        chk_rd("R3 data write aborts key", 1'b0, 8'hFF);
        // R2 clean key
        wr(1'b0, 8'h51); wr(1'b0, 8'h23);
        chk_rd("R2 R4 open, index kept", 1'b0, 8'h70);

        // R7 R8 R9 R10 R11 on device 3
        wr(1'b0, 8'h07); wr(1'b1, 8'h03);
        chk_rd("R7 devsel readback", 1'b1, 8'h03);
        wr(1'b0, 8'h30); wr(1'b1, 8'hFF);
        chk_rd("R8 enable readback", 1'b1, 8'h01);
        chk("R8 enable output", 32'(dev_en_o), 32'h008);
        wr(1'b0, 8'h60); wr(1'b1, 8'h12);
        wr(1'b0, 8'h61); wr(1'b1, 8'h34);
        chk("R9 base dev3", 32'(dev_base_o[48 +: 16]), 32'h1234);
        wr(1'b0, 8'h70); wr(1'b1, 8'h05);
        wr(1'b0, 8'h72); wr(1'b1, 8'h0C);
        wr(1'b0, 8'h74); wr(1'b1, 8'h01);
        chk("R10 irq dev3", 32'(dev_irq_o[24 +: 8]), 32'h05);
        chk("R10 irq2 dev3", 32'(dev_irq2_o[24 +: 8]), 32'h0C);
        chk("R10 dma dev3", 32'(dev_dma_o[24 +: 8]), 32'h01);
        for (int m = 0; m < NM; m++) begin
            wr(1'b0, 8'hF0 + 8'(m)); wr(1'b1, 8'hA0 + 8'(m));
        end
        wr(1'b0, 8'hF2);
        chk_rd("R11 mode readback", 1'b1, 8'hA2);
        // R7 out of range then top of range
        wr(1'b0, 8'h07); wr(1'b1, 8'd9);
        chk_rd("R7 out of range ignored", 1'b1, 8'h03);
        wr(1'b1, 8'd8);
        chk_rd("R7 top of range", 1'b1, 8'h08);
        wr(1'b0, 8'hF2); wr(1'b1, 8'h5A);
        wr(1'b0, 8'h07); wr(1'b1, 8'h03);
        wr(1'b0, 8'hF2);
        chk_rd("R11 bank 3 mode untouched", 1'b1, 8'hA2);
        // R13 undefined index
        wr(1'b0, 8'h45); wr(1'b1, 8'h77);
        chk_rd("R13 undefined reads zero", 1'b1, 8'h00);
        compare_all("R13 after undefined write");
        // R12 soft reset
        wr(1'b0, 8'h02); wr(1'b1, 8'h00);
        chk("R12 bit0 clear no effect", 32'(dev_base_o[48 +: 16]), 32'h1234);
        chk_rd("R12 reads zero", 1'b1, 8'h00);
        wr(1'b1, 8'h01);
        chk("R12 base cleared", 32'(dev_base_o[48 +: 16]), 32'h0);
        chk("R12 dma restored", 32'(dev_dma_o[24 +: 8]), 32'h04);
        chk_rd("R12 still open, index 0", 1'b0, 8'h00);
        compare_all("R12 after soft reset");

        // random phase
        void'($urandom(32'd20240611));
        pick[0] = 8'h51; pick[1] = 8'h23; pick[2] = 8'hBB; pick[3] = 8'h07;
        pick[4] = 8'h30; pick[5] = 8'h60; pick[6] = 8'h61; pick[7] = 8'h70;
        pick[8] = 8'h72; pick[9] = 8'h74; pick[10] = 8'hF0; pick[11] = 8'hF4;
        pick[12] = 8'hF3; pick[13] = 8'h02; pick[14] = 8'h45; pick[15] = 8'hF1;
        for (int i = 0; i < 600; i++) begin
            logic p;
            logic [7:0] v;
            p = 1'($urandom_range(0, 1));
            if (p) begin
                v = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 10)) : 8'($urandom);
                if (m_idx == 8'h02 && $urandom_range(0, 7) != 0) v[0] = 1'b0;
            end else begin
                v = pick[$urandom_range(0, 15)];
                if (m_st == 0 && $urandom_range(0, 1) == 0) begin
                    wr(1'b0, 8'h51);
                    compare_all("R2 R3 random key");
                    v = 8'h23;
                end
            end
            wr(p, v);
            compare_all("R5 R7 R11 R12 random");
        end

        finish_run();
    end

endmodule